// File: doc/BRIEF.md
# Stereo Gain Arbiter for Automatic Level Control

This block owns the left and right gain codes of a stereo input stage and decides, for every host register write, whether the write reaches the amplifier now, later, or never. The host writes 8-bit codes through a single-cycle write port. Codes with bit 7 set select the amplifier gain region, and codes with bit 7 clear select the digital attenuation region. An external automatic level control (ALC) engine supplies gain requests while ALC is running. The block also holds the engine's parameter registers and keeps them frozen while the engine runs.

A three-state machine sequences the work. In MANUAL, host gain writes apply directly. The ENGAGE transition goes to ALC_RUN when ALC turns on, either through the control register or through the `alc_pin` input. On ENGAGE the left channel's applied code is copied to both channels. In ALC_RUN the engine drives the amplifier region, and host writes to the amplifier region are only remembered. The RELEASE transition goes to RESTORE when ALC turns off. In RESTORE each channel waits, independently of the other, for its own zero-cross strobe or for a timeout counted on the sample strobe, and then takes the last host-written code. The SETTLE transition returns to MANUAL once neither channel is still waiting. The RE-ENGAGE transition goes back to ALC_RUN if ALC turns on again during RESTORE.

Top module: `agc_gain_arbiter`

## Requirements
- R1: After reset both gains are 80h, the timing register reads 00h, the limit register 20h, the reference register E1h, and `alc_active` is 0.
- R2: Outside ALC and restore, a host write to address 01h (left) or 02h (right) appears on that channel's gain one cycle later. `rd_data` always returns the last host-written value of the address on `rd_addr`, including address 00h, whose bit 0 is the ALC enable bit.
- R3: When ALC turns on (control bit 0 at address 00h set, or `alc_pin` high), both gains take the left channel's applied code on the next clock edge, and `alc_active` rises at that same edge.
- R4: In ALC_RUN, a cycle with `eng_valid` high loads each channel's gain with its request, with any code below 80h raised to 80h.
- R5: In ALC_RUN, a host gain write of 80h or above leaves the applied gain unchanged. The value still reads back and becomes that channel's restore target.
- R6: In ALC_RUN, a host gain write of 7Fh or below is applied to that channel's gain on the next edge.
- R7: Writes to the parameter registers (03h timing, 04h limit, 05h reference) are ignored while ALC is on: the read-back and the `cfg_*` outputs keep their old values. Outside ALC these writes are accepted.
- R8: After ALC turns off, a channel's `zc` strobe loads that channel's gain with its last host-written code on the next edge. The other channel is unaffected.
- R9: A channel with no zero-cross takes its restore target on the N-th `smp_stb` pulse after ALC turned off, where N = 128 << timing[1:0] (128, 256, 512 or 1024).
- R10: `alc_active` is high exactly in ALC_RUN. It falls on the edge after ALC turns off, and the block returns to manual writes once both channels are restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle host write strobe |
| wr_addr | input | 8 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Last host-written value at rd_addr |
| alc_pin | input | 1 | External ALC enable |
| eng_valid | input | 1 | ALC engine request valid |
| eng_gain_l | input | 8 | Engine requested left code |
| eng_gain_r | input | 8 | Engine requested right code |
| zc_l | input | 1 | Left zero-cross strobe |
| zc_r | input | 1 | Right zero-cross strobe |
| smp_stb | input | 1 | Sample strobe for the timeout |
| gain_l | output | 8 | Applied left gain code |
| gain_r | output | 8 | Applied right gain code |
| alc_active | output | 1 | High while in ALC_RUN |
| cfg_timing | output | 8 | Frozen timing parameters (bits 1:0 select the timeout) |
| cfg_limit | output | 8 | Frozen limiter parameters |
| cfg_ref | output | 8 | Frozen reference level |

## Verification
The assertions take as given that `zc_l`, `zc_r` and `smp_stb` are single-cycle pulses, and that `eng_valid` and ALC-range host writes arrive only as deliberate stimulus. Nothing about same-cycle ordering between the engine and the host is assumed beyond the stated host-wins rule. The stimulus drives each strobe for exactly one cycle and keeps engine requests apart from host writes. When it tests timeouts, it withholds the zero-cross pulse from the channel under test, so that the zero-cross path and the timeout path are each observed alone.

// File: rtl/agc_arb_pkg.sv
package agc_arb_pkg;

    typedef enum logic [1:0] {
        ST_MANUAL  = 2'd0,
        ST_ALC_RUN = 2'd1,
        ST_RESTORE = 2'd2
    } arb_state_e;

    localparam logic [7:0] ADDR_CTRL   = 8'h00;
    localparam logic [7:0] ADDR_GAIN_L = 8'h01;
    localparam logic [7:0] ADDR_GAIN_R = 8'h02;
    localparam logic [7:0] ADDR_TIMING = 8'h03;
    localparam logic [7:0] ADDR_LIMIT  = 8'h04;
    localparam logic [7:0] ADDR_REFLVL = 8'h05;
    localparam int         NUM_PRM     = 3;

    localparam logic [7:0] AMP_FLOOR   = 8'h80;

    function automatic logic is_amp_code(input logic [7:0] code);
        return code[7];
    endfunction

    function automatic logic [7:0] clamp_amp(input logic [7:0] code);
        return is_amp_code(code) ? code : AMP_FLOOR;
    endfunction

endpackage

// File: rtl/agc_cfg_regs.sv
module agc_cfg_regs
    import agc_arb_pkg::*;
#(
    parameter logic [7:0] RST_GAIN   = 8'h80,
    parameter logic [7:0] RST_TIMING = 8'h00,
    parameter logic [7:0] RST_LIMIT  = 8'h20,
    parameter logic [7:0] RST_REF    = 8'hE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       alc_on,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       ctrl_en,
    output logic [7:0] host_l,
    output logic [7:0] host_r,
    output logic       wr_l,
    output logic       wr_r,
    output logic [7:0] prm_timing,
    output logic [7:0] prm_limit,
    output logic [7:0] prm_ref
);

    localparam logic [8*NUM_PRM-1:0] PRM_RST = {RST_REF, RST_LIMIT, RST_TIMING};

    logic [7:0] ctrl_q;
    logic [7:0] prm_q [NUM_PRM];

    assign wr_l = wr_en && (wr_addr == ADDR_GAIN_L);
    assign wr_r = wr_en && (wr_addr == ADDR_GAIN_R);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 8'h00;
            host_l <= RST_GAIN;
            host_r <= RST_GAIN;
        end else begin
            if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_data;
            if (wr_l) host_l <= wr_data;
            if (wr_r) host_r <= wr_data;
        end
    end

    generate
        for (genvar i = 0; i < NUM_PRM; i++) begin : g_prm
            localparam logic [7:0] MY_ADDR = ADDR_TIMING + 8'(i);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prm_q[i] <= PRM_RST[8*i +: 8];
                end else if (wr_en && wr_addr == MY_ADDR && !alc_on) begin
                    prm_q[i] <= wr_data;
                end
            end
        end
    endgenerate

    assign ctrl_en    = ctrl_q[0];
    assign prm_timing = prm_q[0];
    assign prm_limit  = prm_q[1];
    assign prm_ref    = prm_q[2];

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL:   rd_data = ctrl_q;
            ADDR_GAIN_L: rd_data = host_l;
            ADDR_GAIN_R: rd_data = host_r;
            ADDR_TIMING: rd_data = prm_q[0];
            ADDR_LIMIT:  rd_data = prm_q[1];
            ADDR_REFLVL: rd_data = prm_q[2];
            default:     rd_data = 8'h00;
        endcase
    end

    // R7
    frozen_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_on && wr_en && wr_addr == ADDR_LIMIT) |=> $stable(prm_limit));

    // R7
    frozen_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_on && wr_en && wr_addr == ADDR_TIMING) |=> $stable(prm_timing));

endmodule

// File: rtl/agc_mode_fsm.sv
module agc_mode_fsm
    import agc_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alc_on,
    input  logic       pend_any,
    output arb_state_e state,
    output logic       seed,
    output logic       run,
    output logic       restore_start
);

    arb_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_MANUAL:  if (alc_on) state_d = ST_ALC_RUN;
            ST_ALC_RUN: if (!alc_on) state_d = ST_RESTORE;
            ST_RESTORE: begin
                if (alc_on)         state_d = ST_ALC_RUN;
                else if (!pend_any) state_d = ST_MANUAL;
            end
            default:    state_d = ST_MANUAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_MANUAL;
        else        state <= state_d;
    end

    always_comb begin
        seed          = 1'b0;
        run           = 1'b0;
        restore_start = 1'b0;
        unique case (state)
            ST_MANUAL:  seed = alc_on;
            ST_ALC_RUN: begin
                run           = alc_on;
                restore_start = !alc_on;
            end
            ST_RESTORE: seed = alc_on;
            default:    ;
        endcase
    end

    // R10
    manual_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MANUAL) |-> !pend_any);

    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_start |=> (state == ST_RESTORE));

endmodule

// File: rtl/agc_gain_lane.sv
module agc_gain_lane
    import agc_arb_pkg::*;
#(
    parameter int         TO_BASE  = 128,
    parameter logic [7:0] RST_GAIN = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed,
    input  logic [7:0] seed_val,
    input  logic       run,
    input  logic       restore_start,
    input  logic       wr_gain,
    input  logic [7:0] wr_data,
    input  logic [7:0] host_val,
    input  logic       eng_valid,
    input  logic [7:0] eng_gain,
    input  logic       zc,
    input  logic       smp,
    input  logic [1:0] to_sel,
    output logic [7:0] gain,
    output logic       pending
);

    localparam int CW = $clog2(TO_BASE * 8) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;
    logic [7:0]    target;
    logic          expire;

    assign target = wr_gain ? wr_data : host_val;
    assign expire = smp && (cnt_q == lim_q - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain    <= RST_GAIN;
            pending <= 1'b0;
            cnt_q   <= '0;
            lim_q   <= CW'(TO_BASE);
        end else if (seed) begin
            gain    <= seed_val;
            pending <= 1'b0;
            cnt_q   <= '0;
        end else if (run) begin
            if (wr_gain && !is_amp_code(wr_data)) gain <= wr_data;
            else if (eng_valid)                   gain <= clamp_amp(eng_gain);
        end else if (restore_start) begin
            pending <= 1'b1;
            cnt_q   <= '0;
            lim_q   <= CW'(TO_BASE) << to_sel;
        end else if (pending) begin
            if (zc || expire) begin
                gain    <= target;
                pending <= 1'b0;
                cnt_q   <= '0;
            end else if (smp) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end else if (wr_gain) begin
            gain <= wr_data;
        end
    end

    // R4
    eng_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && eng_valid && !(wr_gain && !wr_data[7])) |=> gain[7]);

    // R5
    amp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_gain && wr_data[7] && !eng_valid) |=> $stable(gain));

    // R6
    att_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_gain && !wr_data[7]) |=> (gain == $past(wr_data)));

    // R8
    zc_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !seed && zc) |=> (!pending && gain == $past(target)));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (cnt_q < lim_q));

endmodule

// File: rtl/agc_gain_arbiter.sv
module agc_gain_arbiter
    import agc_arb_pkg::*;
#(
    parameter int         TO_BASE    = 128,
    parameter logic [7:0] RST_GAIN   = 8'h80,
    parameter logic [7:0] RST_TIMING = 8'h00,
    parameter logic [7:0] RST_LIMIT  = 8'h20,
    parameter logic [7:0] RST_REF    = 8'hE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       alc_pin,
    input  logic       eng_valid,
    input  logic [7:0] eng_gain_l,
    input  logic [7:0] eng_gain_r,
    input  logic       zc_l,
    input  logic       zc_r,
    input  logic       smp_stb,
    output logic [7:0] gain_l,
    output logic [7:0] gain_r,
    output logic       alc_active,
    output logic [7:0] cfg_timing,
    output logic [7:0] cfg_limit,
    output logic [7:0] cfg_ref
);

    localparam int NCH = 2;

    logic       ctrl_en, alc_on;
    logic [7:0] host_l, host_r;
    logic       wr_l, wr_r;
    arb_state_e state;
    logic       seed, run, restore_start;

    logic [7:0] host_v [NCH];
    logic       wr_v   [NCH];
    logic [7:0] eng_v  [NCH];
    logic       zc_v   [NCH];
    logic [7:0] gain_v [NCH];
    logic       pend_v [NCH];

    assign alc_on = ctrl_en | alc_pin;

    agc_cfg_regs #(
        .RST_GAIN(RST_GAIN), .RST_TIMING(RST_TIMING),
        .RST_LIMIT(RST_LIMIT), .RST_REF(RST_REF)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alc_on(alc_on), .rd_addr(rd_addr),
        .rd_data(rd_data), .ctrl_en(ctrl_en), .host_l(host_l),
        .host_r(host_r), .wr_l(wr_l), .wr_r(wr_r),
        .prm_timing(cfg_timing), .prm_limit(cfg_limit), .prm_ref(cfg_ref)
    );

    agc_mode_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .alc_on(alc_on),
        .pend_any(pend_v[0] | pend_v[1]), .state(state), .seed(seed),
        .run(run), .restore_start(restore_start)
    );

    assign host_v[0] = host_l;
    assign host_v[1] = host_r;
    assign wr_v[0]   = wr_l;
    assign wr_v[1]   = wr_r;
    assign eng_v[0]  = eng_gain_l;
    assign eng_v[1]  = eng_gain_r;
    assign zc_v[0]   = zc_l;
    assign zc_v[1]   = zc_r;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
            agc_gain_lane #(.TO_BASE(TO_BASE), .RST_GAIN(RST_GAIN)) lane_i (
                .clk(clk), .rst_n(rst_n), .seed(seed), .seed_val(gain_v[0]),
                .run(run), .restore_start(restore_start), .wr_gain(wr_v[ch]),
                .wr_data(wr_data), .host_val(host_v[ch]), .eng_valid(eng_valid),
                .eng_gain(eng_v[ch]), .zc(zc_v[ch]), .smp(smp_stb),
                .to_sel(cfg_timing[1:0]), .gain(gain_v[ch]), .pending(pend_v[ch])
            );
        end
    endgenerate

    assign gain_l     = gain_v[0];
    assign gain_r     = gain_v[1];
    assign alc_active = (state == ST_ALC_RUN);

    // R3
    seed_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (gain_l == gain_r && alc_active));

    // R3
    seed_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (gain_r == $past(gain_l)));

endmodule

// File: tb/agc_gain_arbiter_tb.sv
`timescale 1ns/1ps
module agc_gain_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic       alc_pin = 1'b0, eng_valid = 1'b0;
    logic [7:0] eng_gain_l = '0, eng_gain_r = '0;
    logic       zc_l = 1'b0, zc_r = 1'b0, smp_stb = 1'b0;
    logic [7:0] gain_l, gain_r, cfg_timing, cfg_limit, cfg_ref;
    logic       alc_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        int         sel;
        logic [7:0] exp;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    agc_gain_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .alc_pin(alc_pin), .eng_valid(eng_valid), .eng_gain_l(eng_gain_l),
        .eng_gain_r(eng_gain_r), .zc_l(zc_l), .zc_r(zc_r), .smp_stb(smp_stb),
        .gain_l(gain_l), .gain_r(gain_r), .alc_active(alc_active),
        .cfg_timing(cfg_timing), .cfg_limit(cfg_limit), .cfg_ref(cfg_ref)
    );

    function automatic logic [7:0] pick(int sel);
        case (sel)
            0: return gain_l;
            1: return gain_r;
            2: return rd_data;
            3: return {7'd0, alc_active};
            4: return cfg_timing;
            5: return cfg_limit;
            default: return cfg_ref;
        endcase
    endfunction

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = pick(it.sel);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic push(int sel, logic [7:0] exp, string tag);
        exp_item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        @(negedge clk); #1;
    endtask

    task automatic host_wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic read_chk(logic [7:0] a, logic [7:0] exp, string tag);
        rd_addr = a;
        push(2, exp, tag);
        drain();
    endtask

    task automatic pulse_smp(int n);
        for (int i = 0; i < n; i++) begin
            smp_stb = 1'b1; tick();
            smp_stb = 1'b0; tick();
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        push(0, 8'h80, "R1 gain_l"); push(1, 8'h80, "R1 gain_r");
        push(3, 8'h00, "R1 alc_active"); push(4, 8'h00, "R1 timing");
        push(5, 8'h20, "R1 limit"); push(6, 8'hE1, "R1 ref");
        drain();

        // R2 manual writes
        host_wr(8'h01, 8'hA0);
        host_wr(8'h02, 8'hC4);
        push(0, 8'hA0, "R2 manual left"); push(1, 8'hC4, "R2 manual right");
        drain();
        read_chk(8'h01, 8'hA0, "R2 readback left");
        // R7 accepted outside ALC
        host_wr(8'h04, 8'h35);
        push(5, 8'h35, "R7 limit write outside ALC");
        drain();

        // R3 engage by pin, seed from left
        alc_pin = 1'b1; tick();
        push(0, 8'hA0, "R3 seed left"); push(1, 8'hA0, "R3 seed right");
        push(3, 8'h01, "R10 active in run");
        drain();

        // R7 frozen while on
        host_wr(8'h04, 8'h77);
        push(5, 8'h35, "R7 limit frozen");
        drain();
        read_chk(8'h04, 8'h35, "R7 limit readback frozen");

        // R4 engine request with clamp
        eng_gain_l = 8'h40; eng_gain_r = 8'hD0; eng_valid = 1'b1; tick();
        eng_valid = 1'b0;
        push(0, 8'h80, "R4 clamp left"); push(1, 8'hD0, "R4 pass right");
        drain();

        // R5 amplifier-range write locked out
        host_wr(8'h01, 8'hF0);
        push(0, 8'h80, "R5 amp write ignored");
        drain();
        read_chk(8'h01, 8'hF0, "R5 readback keeps write");

        // R6 attenuation write live
        host_wr(8'h02, 8'h30);
        push(1, 8'h30, "R6 att write applied");
        drain();
        host_wr(8'h02, 8'hB8);
        push(1, 8'h30, "R5 right amp write ignored");
        drain();

        // release
        alc_pin = 1'b0; tick();
        push(3, 8'h00, "R10 active falls");
        push(0, 8'h80, "R8 left held"); push(1, 8'h30, "R8 right held");
        drain();

        // R8 zero-cross on left only
        zc_l = 1'b1; tick(); zc_l = 1'b0;
        push(0, 8'hF0, "R8 left restored on zc");
        push(1, 8'h30, "R8 right unaffected");
        drain();

        // R9 right by timeout of 128 samples
        pulse_smp(127);
        push(1, 8'h30, "R9 right before 128th strobe");
        drain();
        pulse_smp(1);
        push(1, 8'hB8, "R9 right at 128th strobe");
        drain();
        tick();

        // R2 manual again after settle
        host_wr(8'h01, 8'h11);
        push(0, 8'h11, "R10 manual after settle");
        drain();

        // second round: register-bit engage, timeout 256
        host_wr(8'h03, 8'h01);
        push(4, 8'h01, "R7 timing write outside ALC");
        drain();
        host_wr(8'h00, 8'h01);
        tick();
        push(0, 8'h11, "R3 reg seed left"); push(1, 8'h11, "R3 reg seed right");
        push(3, 8'h01, "R10 active via reg");
        drain();
        read_chk(8'h00, 8'h01, "R2 ctrl readback");
        host_wr(8'h01, 8'h9A);
        push(0, 8'h11, "R5 left amp write ignored");
        drain();
        host_wr(8'h03, 8'h03);
        push(4, 8'h01, "R7 timing frozen");
        drain();
        host_wr(8'h00, 8'h00);
        tick();
        push(3, 8'h00, "R10 falls via reg");
        drain();

        zc_r = 1'b1; tick(); zc_r = 1'b0;
        push(1, 8'hB8, "R8 right restored on zc");
        push(0, 8'h11, "R8 left still waiting");
        drain();

        pulse_smp(255);
        push(0, 8'h11, "R9 left before 256th strobe");
        drain();
        pulse_smp(1);
        push(0, 8'h9A, "R9 left at 256th strobe");
        drain();
        tick();

        host_wr(8'h02, 8'h05);
        push(1, 8'h05, "R2 manual right after round two");
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule